// File: doc/BRIEF.md
# Banked GPIO Register Controller

This block is the register front end for up to 128 general-purpose pins, organised as four banks of 32. Software on a simple synchronous register bus sets each pin's direction, changes the output latch only through write-to-set and write-to-clear words, and reads back a per-bank level word. That level word shows the latched output for pins configured as outputs and the live input for pins configured as inputs. Each pin gets an output value and an output enable. Per bank the block also holds rising and falling edge enable words and two alternate-function words. These are plain storage for neighbouring logic.

The address map is irregular. Banks 0 to 2 interleave their words in a packed region starting at offset 0x000. Bank 3 repeats that layout in a separate window shifted by 0x100. The alternate-function words follow the packed region in pairs. A read of a level word raises a one-cycle notify strobe, so a companion block can react to software polling. Edge detection and interrupt generation live elsewhere, so the edge-status words here always read as zero.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: After reset every pin is an input: pin_oe and pin_out are all zero, and every storage word (direction, latch, last set value, edge enables, alternate-function words) reads zero.
- R2: Byte offsets per bank b in 0..2 are level 0x000+4b, direction 0x00C+4b, set 0x018+4b, clear 0x024+4b, rising enable 0x030+4b, falling enable 0x03C+4b and edge status 0x048+4b. Bank 3 uses the bank-0 offsets plus 0x100.
- R3: A write to a set word ORs the data into that bank's output latch. A write to a clear word clears every latch bit that is 1 in the data. No other write changes the latch.
- R4: pin_oe equals the direction word, where 1 means output. pin_out equals latch AND direction. Both reflect a direction, set or clear write from the cycle after that write.
- R5: A level read returns latch bits where direction is 1 and pin_in bits where direction is 0.
- R6: Reading a set word returns the last value written to it. Reading a clear word returns the fixed constant CLR_READ_VALUE (default 0xC1EA0000).
- R7: The edge-enable words and the alternate-function words are read/write storage. The low and high alternate-function words of bank b are at 0x054+8b and 0x058+8b. Edge-status words read zero and ignore writes.
- R8: Read data appears on bus_rdata in the cycle after bus_ren and holds until the next read. A level read pulses level_rd_pulse for exactly that one cycle, and no other access does.
- R9: Offsets at or above 0x200 read as zero, ignore writes and do not pulse bus_err.
- R10: An offset below 0x200 that matches no word reads as zero, ignores writes, and pulses bus_err for one cycle after the access. Misaligned offsets count as unmatched.
- R11: Lines at index NUM_LINES and above do not exist. Their direction and latch bits stay zero and read as zero, and they read as zero in the level word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wen | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_ren | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_ren |
| bus_err | output | 1 | One-cycle pulse after an access to an unmatched offset below 0x200 |
| level_rd_pulse | output | 1 | One-cycle pulse after a level-word read |
| pin_in | input | NUM_LINES | Input levels of the pins |
| pin_out | output | NUM_LINES | Driven value per pin |
| pin_oe | output | NUM_LINES | Output enable per pin |

## Verification
A corrupted direction or latch bit appears on pin_oe or pin_out from the very next cycle, well before any readback. A wrong decode shows up as a write that lands in the wrong bank or word. That write shows on the pins, or in the first later read of the affected word. A bad error or notify decision shows on bus_err or level_rd_pulse in the cycle after the offending access. For that reason the bench checks both strobes on every access, not only on those where a pulse is expected.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  localparam int BANKS     = 4;
  localparam int BANK_W    = 32;
  localparam int MAX_LINES = BANKS * BANK_W;

  typedef enum logic [3:0] {
    K_LEVEL = 4'd0,
    K_DIR   = 4'd1,
    K_SET   = 4'd2,
    K_CLR   = 4'd3,
    K_RISE  = 4'd4,
    K_FALL  = 4'd5,
    K_STAT  = 4'd6,
    K_AFLO  = 4'd7,
    K_AFHI  = 4'd8,
    K_NONE  = 4'd9
  } reg_kind_e;

  typedef struct packed {
    reg_kind_e  kind;
    logic [1:0] bank;
    logic       in_win;
  } dec_t;

  // Mask of lines that exist in bank b when only 'lines' pins are present
  function automatic logic [BANK_W-1:0] bank_mask(int lines, int b);
    int n;
    n = lines - BANK_W * b;
    if (n <= 0)      return '0;
    if (n >= BANK_W) return '1;
    return (32'h1 << n) - 32'h1;
  endfunction

endpackage

// File: rtl/gpio_addr_dec.sv
module gpio_addr_dec
  import gpio_bank_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic [ADDR_W-1:0] addr,
  output dec_t              dec
);

  localparam logic [ADDR_W-1:0] WIN_END = ADDR_W'(512);
  localparam logic [5:0] PACKED_WORDS = 6'd21;  // 7 kinds x 3 banks
  localparam logic [5:0] AF_END       = 6'd29;  // 4 banks x 2 words after that
  localparam logic [5:0] HI_LAST      = 6'd18;  // last kind word in the bank-3 window

  logic [5:0] word;
  logic [3:0] grp;
  logic [1:0] rem;
  logic [2:0] af_idx;

  // Word index inside a 256-byte half. In the packed half, three banks
  // interleave per kind, so the quotient gives the kind and the remainder the bank.
  always_comb begin
    word   = addr[7:2];
    grp    = 4'(word / 6'd3);
    rem    = 2'(word % 6'd3);
    af_idx = 3'(word - PACKED_WORDS);

    dec.kind   = K_NONE;
    dec.bank   = 2'd0;
    dec.in_win = (addr < WIN_END);

    if (dec.in_win && (addr[1:0] == 2'b00)) begin
      if (!addr[8]) begin
        if (word < PACKED_WORDS) begin
          dec.kind = reg_kind_e'(grp);
          dec.bank = rem;
        end else if (word < AF_END) begin
          dec.kind = af_idx[0] ? K_AFHI : K_AFLO;
          dec.bank = af_idx[2:1];
        end
      end else if ((word <= HI_LAST) && (rem == 2'd0)) begin
        dec.kind = reg_kind_e'(grp);
        dec.bank = 2'd3;
      end
    end
  end

endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
  import gpio_bank_pkg::*;
#(
  parameter logic [BANK_W-1:0] LINE_MASK = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  reg_kind_e         wr_kind,
  input  logic [BANK_W-1:0] wr_data,
  input  logic [BANK_W-1:0] pin_lvl,
  output logic [BANK_W-1:0] dir_q,
  output logic [BANK_W-1:0] latch_q,
  output logic [BANK_W-1:0] setw_q,
  output logic [BANK_W-1:0] rise_q,
  output logic [BANK_W-1:0] fall_q,
  output logic [BANK_W-1:0] aflo_q,
  output logic [BANK_W-1:0] afhi_q,
  output logic [BANK_W-1:0] level
);

  logic [BANK_W-1:0] dir_n, latch_n, setw_n, rise_n, fall_n, aflo_n, afhi_n;

  always_comb begin
    dir_n   = dir_q;
    latch_n = latch_q;
    setw_n  = setw_q;
    rise_n  = rise_q;
    fall_n  = fall_q;
    aflo_n  = aflo_q;
    afhi_n  = afhi_q;
    case (wr_kind)
      K_DIR:  dir_n   = wr_data & LINE_MASK;
      K_SET: begin
        latch_n = latch_q | (wr_data & LINE_MASK);
        setw_n  = wr_data;
      end
      K_CLR:  latch_n = latch_q & ~wr_data;
      K_RISE: rise_n  = wr_data;
      K_FALL: fall_n  = wr_data;
      K_AFLO: aflo_n  = wr_data;
      K_AFHI: afhi_n  = wr_data;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q   <= '0;
      latch_q <= '0;
      setw_q  <= '0;
      rise_q  <= '0;
      fall_q  <= '0;
      aflo_q  <= '0;
      afhi_q  <= '0;
    end else if (wr_en) begin
      dir_q   <= dir_n;
      latch_q <= latch_n;
      setw_q  <= setw_n;
      rise_q  <= rise_n;
      fall_q  <= fall_n;
      aflo_q  <= aflo_n;
      afhi_q  <= afhi_n;
    end
  end

  assign level = ((latch_q & dir_q) | (pin_lvl & ~dir_q)) & LINE_MASK;

  logic wr_set, wr_clr;
  assign wr_set = wr_en && (wr_kind == K_SET);
  assign wr_clr = wr_en && (wr_kind == K_CLR);

  AST_SET_ONLY_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
    wr_set |=> ((latch_q & $past(latch_q)) == $past(latch_q)));  // R3
  AST_CLR_ONLY_LOWERS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_clr |=> ((latch_q & ~$past(latch_q)) == '0));  // R3
  AST_LATCH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_set || wr_clr) |=> $stable(latch_q));  // R3
  AST_ABSENT_LINES_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ((dir_q | latch_q) & ~LINE_MASK) == '0);  // R11

endmodule

// File: rtl/gpio_rd_port.sv
module gpio_rd_port
  import gpio_bank_pkg::*;
#(
  parameter logic [BANK_W-1:0] CLR_READ_VALUE = 32'hC1EA_0000
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         ren,
  input  logic                         wen,
  input  dec_t                         dec,
  input  logic [BANKS-1:0][BANK_W-1:0] lvl_a,
  input  logic [BANKS-1:0][BANK_W-1:0] dir_a,
  input  logic [BANKS-1:0][BANK_W-1:0] setw_a,
  input  logic [BANKS-1:0][BANK_W-1:0] rise_a,
  input  logic [BANKS-1:0][BANK_W-1:0] fall_a,
  input  logic [BANKS-1:0][BANK_W-1:0] aflo_a,
  input  logic [BANKS-1:0][BANK_W-1:0] afhi_a,
  output logic [BANK_W-1:0]            rdata,
  output logic                         notify,
  output logic                         err
);

  logic [BANK_W-1:0] sel;
  logic              notify_n, err_n;

  always_comb begin
    case (dec.kind)
      K_LEVEL: sel = lvl_a[dec.bank];
      K_DIR:   sel = dir_a[dec.bank];
      K_SET:   sel = setw_a[dec.bank];
      K_CLR:   sel = CLR_READ_VALUE;
      K_RISE:  sel = rise_a[dec.bank];
      K_FALL:  sel = fall_a[dec.bank];
      K_AFLO:  sel = aflo_a[dec.bank];
      K_AFHI:  sel = afhi_a[dec.bank];
      default: sel = '0;
    endcase
    notify_n = ren && (dec.kind == K_LEVEL);
    err_n    = (ren || wen) && dec.in_win && (dec.kind == K_NONE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata  <= '0;
      notify <= 1'b0;
      err    <= 1'b0;
    end else begin
      if (ren) rdata <= sel;
      notify <= notify_n;
      err    <= err_n;
    end
  end

  logic far_rd, far_acc;
  assign far_rd  = ren && !dec.in_win;
  assign far_acc = (ren || wen) && !dec.in_win;

  AST_FAR_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    far_rd |=> (rdata == '0));  // R9
  AST_FAR_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    far_acc |=> !err);  // R9
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ren |=> $stable(rdata));  // R8

endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
  import gpio_bank_pkg::*;
#(
  parameter int                NUM_LINES      = 128,
  parameter int                ADDR_W         = 12,
  parameter logic [BANK_W-1:0] CLR_READ_VALUE = 32'hC1EA_0000
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic                 bus_wen,
  input  logic [BANK_W-1:0]    bus_wdata,
  input  logic                 bus_ren,
  output logic [BANK_W-1:0]    bus_rdata,
  output logic                 bus_err,
  output logic                 level_rd_pulse,
  input  logic [NUM_LINES-1:0] pin_in,
  output logic [NUM_LINES-1:0] pin_out,
  output logic [NUM_LINES-1:0] pin_oe
);

  localparam int PAD = MAX_LINES - NUM_LINES;

  dec_t dec;
  logic [MAX_LINES-1:0]         pin_in_full, out_full, oe_full;
  logic [BANKS-1:0][BANK_W-1:0] lvl_a, dir_a, latch_a, setw_a, rise_a, fall_a, aflo_a, afhi_a;

  generate
    if (PAD == 0) begin : g_full
      assign pin_in_full = pin_in;
    end else begin : g_pad
      assign pin_in_full = {{PAD{1'b0}}, pin_in};
    end
  endgenerate

  gpio_addr_dec #(.ADDR_W(ADDR_W)) u_dec (
    .addr (bus_addr),
    .dec  (dec)
  );

  genvar b;
  generate
    for (b = 0; b < BANKS; b++) begin : g_bank
      logic wr_b;
      assign wr_b = bus_wen && (dec.kind != K_NONE) && (dec.bank == 2'(b));

      gpio_bank_regs #(.LINE_MASK(bank_mask(NUM_LINES, b))) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_b),
        .wr_kind (dec.kind),
        .wr_data (bus_wdata),
        .pin_lvl (pin_in_full[b*BANK_W +: BANK_W]),
        .dir_q   (dir_a[b]),
        .latch_q (latch_a[b]),
        .setw_q  (setw_a[b]),
        .rise_q  (rise_a[b]),
        .fall_q  (fall_a[b]),
        .aflo_q  (aflo_a[b]),
        .afhi_q  (afhi_a[b]),
        .level   (lvl_a[b])
      );

      assign oe_full[b*BANK_W +: BANK_W]  = dir_a[b];
      assign out_full[b*BANK_W +: BANK_W] = latch_a[b] & dir_a[b];
    end
  endgenerate

  gpio_rd_port #(.CLR_READ_VALUE(CLR_READ_VALUE)) u_rd (
    .clk    (clk),
    .rst_n  (rst_n),
    .ren    (bus_ren),
    .wen    (bus_wen),
    .dec    (dec),
    .lvl_a  (lvl_a),
    .dir_a  (dir_a),
    .setw_a (setw_a),
    .rise_a (rise_a),
    .fall_a (fall_a),
    .aflo_a (aflo_a),
    .afhi_a (afhi_a),
    .rdata  (bus_rdata),
    .notify (level_rd_pulse),
    .err    (bus_err)
  );

  assign pin_out = out_full[NUM_LINES-1:0];
  assign pin_oe  = oe_full[NUM_LINES-1:0];

  AST_DRIVE_NEEDS_OE: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_out & ~pin_oe) == '0);  // R4
  AST_NOTIFY_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    level_rd_pulse |-> $past(bus_ren));  // R8
  AST_ERR_AFTER_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> $past(bus_ren || bus_wen));  // R10
  AST_PINS_STABLE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wen |=> ($stable(pin_oe) && $stable(pin_out)));  // R4

endmodule

// File: tb/tb_gpio_bank_ctrl.sv
module tb_gpio_bank_ctrl;

  localparam int NL = 100;
  localparam logic [31:0] CLRV = 32'hC1EA_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] bus_addr = '0;
  logic        bus_wen = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic        bus_ren = 1'b0;
  logic [31:0] bus_rdata;
  logic        bus_err;
  logic        level_rd_pulse;
  logic [NL-1:0] pin_in = '0;
  logic [NL-1:0] pin_out, pin_oe;

  always #2.5 clk = ~clk;  // 200 MHz

  gpio_bank_ctrl #(.NUM_LINES(NL), .ADDR_W(12), .CLR_READ_VALUE(CLRV)) dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wen(bus_wen),
    .bus_wdata(bus_wdata), .bus_ren(bus_ren), .bus_rdata(bus_rdata),
    .bus_err(bus_err), .level_rd_pulse(level_rd_pulse),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  typedef struct {
    logic        rd;
    logic [31:0] data;
    logic        nt;
    logic        er;
    string       tag;
  } item_t;

  item_t exp_q[$];
  int checks = 0;
  int fails  = 0;
  logic fire = 1'b0;
  logic done = 1'b0;

  task automatic chk(string tag, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Driver: one access per call, starting and ending on a falling edge
  task automatic acc(input logic [11:0] a, input logic w, input logic [31:0] d,
                     input logic r, input logic [31:0] exp_d,
                     input logic exp_nt, input logic exp_er, input string tag);
    item_t it;
    it.rd = r; it.data = exp_d; it.nt = exp_nt; it.er = exp_er; it.tag = tag;
    exp_q.push_back(it);
    bus_addr = a; bus_wen = w; bus_wdata = d; bus_ren = r;
    @(negedge clk);
    bus_wen = 1'b0; bus_ren = 1'b0;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d, input string tag);
    acc(a, 1'b1, d, 1'b0, '0, 1'b0, 1'b0, tag);
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] e, input string tag);
    acc(a, 1'b0, '0, 1'b1, e, 1'b0, 1'b0, tag);
  endtask

  // Monitor: compare each access result on the falling edge after it
  always @(posedge clk) fire <= bus_ren | bus_wen;

  always @(negedge clk) begin
    if (fire) begin
      if (exp_q.size() == 0) begin
        checks++; fails++;
        $display("FAIL scoreboard: result with no expected item (actual 1 expected 0)");
      end else begin
        item_t it;
        it = exp_q.pop_front();
        if (it.rd) chk({it.tag, " rdata"}, 128'(bus_rdata), 128'(it.data));
        chk({it.tag, " notify"}, 128'(level_rd_pulse), 128'(it.nt));
        chk({it.tag, " err"}, 128'(bus_err), 128'(it.er));
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 oe", 128'(pin_oe), 128'(0));
    chk("R1 out", 128'(pin_out), 128'(0));
    rd(12'h00C, 32'h0, "R1 dir0");
    rd(12'h018, 32'h0, "R1 set0");
    rd(12'h054, 32'h0, "R1 aflo0");
    rd(12'h130, 32'h0, "R1 rise3");

    // R4, R3 bank 0 outputs
    wr(12'h00C, 32'h0000_FFFF, "R2 dir0 wr");
    wr(12'h018, 32'h00FF_00F0, "R3 set0 wr");
    chk("R4 oe0", 128'(pin_oe[31:0]), 128'(32'h0000_FFFF));
    chk("R4 out0", 128'(pin_out[31:0]), 128'(32'h0000_00F0));
    wr(12'h024, 32'h0000_0030, "R3 clr0 wr");
    chk("R3 clear", 128'(pin_out[31:0]), 128'(32'h0000_00C0));
    wr(12'h018, 32'h0000_0001, "R3 set0 wr2");
    chk("R3 set or", 128'(pin_out[31:0]), 128'(32'h0000_00C1));

    // R5, R8 level merge and notify
    pin_in[31:0] = 32'hA5A5_1234;
    acc(12'h000, 1'b0, '0, 1'b1, 32'hA5A5_00C1, 1'b1, 1'b0, "R5 R8 level0");
    @(negedge clk);
    chk("R8 notify one cycle", 128'(level_rd_pulse), 128'(0));
    chk("R8 rdata holds", 128'(bus_rdata), 128'(32'hA5A5_00C1));
    wr(12'h00C, 32'hFFFF_0000, "R4 dir0 flip");
    chk("R4 oe flip", 128'(pin_oe[31:0]), 128'(32'hFFFF_0000));
    chk("R4 out flip", 128'(pin_out[31:0]), 128'(32'h00FF_0000));
    acc(12'h000, 1'b0, '0, 1'b1, 32'h00FF_1234, 1'b1, 1'b0, "R5 level0 b");

    // R6 set/clear readback
    rd(12'h018, 32'h0000_0001, "R6 set0 last");
    rd(12'h024, CLRV, "R6 clr0 const");

    // R2 other banks
    wr(12'h010, 32'hFFFF_FFFF, "R2 dir1 wr");
    wr(12'h01C, 32'h8000_0001, "R2 set1 wr");
    chk("R2 out1", 128'(pin_out[63:32]), 128'(32'h8000_0001));
    wr(12'h014, 32'h0000_0F00, "R2 dir2 wr");
    wr(12'h020, 32'h0000_0100, "R2 set2 wr");
    wr(12'h02C, 32'h0000_0000, "R2 clr2 wr");
    chk("R2 out2", 128'(pin_out[95:64]), 128'(32'h0000_0100));
    chk("R2 oe2", 128'(pin_oe[95:64]), 128'(32'h0000_0F00));
    chk("R2 out0 untouched", 128'(pin_out[31:0]), 128'(32'h00FF_0000));

    // R2, R11 bank 3 in the shifted window, only 4 lines present
    wr(12'h10C, 32'hFFFF_FFFF, "R11 dir3 wr");
    rd(12'h10C, 32'h0000_000F, "R11 dir3 read");
    wr(12'h118, 32'hFFFF_FFFF, "R2 set3 wr");
    wr(12'h124, 32'h0000_0005, "R2 clr3 wr");
    chk("R2 out3", 128'(pin_out[99:96]), 128'(4'hA));
    chk("R11 oe3", 128'(pin_oe[99:96]), 128'(4'hF));
    pin_in[99:96] = 4'h3;
    acc(12'h100, 1'b0, '0, 1'b1, 32'h0000_000A, 1'b1, 1'b0, "R11 level3");
    rd(12'h118, 32'hFFFF_FFFF, "R6 set3 last");

    // R7 storage words and edge status
    wr(12'h054, 32'h1111_1111, "R7 aflo0 wr");
    wr(12'h070, 32'h8888_8888, "R7 afhi3 wr");
    wr(12'h034, 32'hCAFE_0001, "R7 rise1 wr");
    wr(12'h13C, 32'h0BAD_F00D, "R7 fall3 wr");
    wr(12'h048, 32'hFFFF_FFFF, "R7 stat0 wr");
    rd(12'h054, 32'h1111_1111, "R7 aflo0");
    rd(12'h070, 32'h8888_8888, "R7 afhi3");
    rd(12'h058, 32'h0, "R7 afhi0");
    rd(12'h034, 32'hCAFE_0001, "R7 rise1");
    rd(12'h13C, 32'h0BAD_F00D, "R7 fall3");
    rd(12'h048, 32'h0, "R7 stat0");

    // R9 out of window
    wr(12'h20C, 32'h0, "R9 far wr dir alias");
    wr(12'h218, 32'hFFFF_FFFF, "R9 far wr set alias");
    chk("R9 oe unchanged", 128'(pin_oe[31:0]), 128'(32'hFFFF_0000));
    chk("R9 out unchanged", 128'(pin_out[31:0]), 128'(32'h00FF_0000));
    rd(12'h200, 32'h0, "R9 far read");
    rd(12'h00C, 32'hFFFF_0000, "R9 dir0 intact");

    // R10 unmatched offsets below the window end
    acc(12'h074, 1'b0, '0, 1'b1, 32'h0, 1'b0, 1'b1, "R10 read 0x074");
    acc(12'h00D, 1'b1, 32'h0, 1'b0, '0, 1'b0, 1'b1, "R10 misaligned wr");
    acc(12'h104, 1'b0, '0, 1'b1, 32'h0, 1'b0, 1'b1, "R10 read 0x104");
    acc(12'h0D0, 1'b1, 32'hFFFF_FFFF, 1'b0, '0, 1'b0, 1'b1, "R10 wr 0x0D0");
    chk("R10 oe unchanged", 128'(pin_oe[31:0]), 128'(32'hFFFF_0000));
    rd(12'h00C, 32'hFFFF_0000, "R10 dir0 intact");

    @(negedge clk);
    @(negedge clk);
    chk("scoreboard drained", 128'(exp_q.size()), 128'(0));
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule